// File: doc/BRIEF.md
# Threshold-Crossing Time Estimator for Sampled Edges

This block takes one burst of digitized samples of a filtered, latched trigger edge and returns the time at which that edge crossed its own mid level, with a resolution much finer than one sample. The samples come in at the converter clock rate. A marker flags the first sample of each burst. The block measures the settled low level at the head of the burst and the settled high level at its tail. It places the threshold exactly between the two, so offset and gain drift in the analog path cancel out.

The block scans the stored burst for the first sample pair that brackets the threshold. Between those two samples it forms a smooth interpolated curve from four neighbouring samples. It runs a fixed number of halving steps on that curve, then closes the remaining sub-interval with one linear step. The timestamp is the bracketing sample index joined to a binary fraction, minus an offset that stands for the calibrated analog filter delay. A flag marks bursts whose swing is too small, and for those no timestamp is given.

Top module: `edge_cross_est`

## Requirements
- R1: A burst is BURST (default 32) samples that have `smp_valid` high. Its first sample carries `smp_start`. Cycles with `smp_valid` low inside a burst are skipped and do not count. A start marker opens a burst only when the block is idle or in its result cycle.
- R2: The low level is the mean of the first AVG (default 8) samples of the burst and the high level is the mean of the last AVG samples. The threshold is their exact midpoint and is never rounded.
- R3: The bracketing index k is the smallest k in 0..BURST-2 for which sample k is below the threshold and sample k+1 is at or above it.
- R4: Between samples k and k+1 the curve is a Catmull-Rom cubic through samples k-1, k, k+1 and k+2. An index below 0 is clamped to 0 and an index above BURST-1 is clamped to BURST-1.
- R5: ITER (default 8) halving steps keep the curve below the threshold at the lower end of the interval and at or above it at the upper end. A final linear step adds FRACW-ITER more bits. The fraction (FRACW = 12 bits, unit 1/4096 sample) lies within 2 units of the exact crossing of the cubic.
- R6: `res_time` = k*4096 + fraction - `delay_ofs`, modulo 2^17. `delay_ofs` is read while the result is formed.
- R7: When the high-level sum is below the low-level sum plus AVG*MIN_SWING (default mean swing 16 codes), or no pair brackets the threshold, `res_ok` is 0 and `res_time` is 0. A swing of exactly MIN_SWING is valid.
- R8: Each accepted burst yields exactly one result, marked by a one-cycle pulse on `res_valid`.
- R9: Start markers and samples that arrive after capture and before the result cycle are ignored, and the result is unchanged.
- R10: A start marker in the result cycle opens the next burst without losing either result.
- R11: During and right after reset, `res_valid`, `res_ok` and `res_time` are 0.
- R12: The result pulse comes at most BURST+FRACW+6 cycles after the last sample of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_start | input | 1 | First sample of a burst |
| smp_data | input | DW (12) | Unsigned sample value |
| delay_ofs | input | log2(BURST)+FRACW (17) | Filter delay to subtract, in 1/4096 sample units |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | Timestamp is valid |
| res_time | output | log2(BURST)+FRACW (17) | Crossing time minus delay offset |

## Verification
Two functions can fall in the same cycle: emitting the result of one burst and accepting the start marker of the next. The bench provokes this by driving the next burst's first sample, with its marker, on the very clock where it sees `res_valid`. It judges the overlap by checking both timestamps against independently computed crossings of the cubic, and by checking that the number of results matches the number of bursts. It also sends false start markers while a burst is being computed and expects them to have no effect.

// File: rtl/ect_pkg.sv
package ect_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_CAP,
      S_SCAN,
      S_BIS,
      S_DIV,
      S_FIN,
      S_DONE
   } ect_state_t;
endpackage

// File: rtl/ect_capture.sv
module ect_capture #(
   parameter int DW    = 12,
   parameter int BURST = 32,
   parameter int AVG   = 8,
   localparam int IDXW = $clog2(BURST),
   localparam int CW   = $clog2(BURST + 1),
   localparam int SUMW = DW + $clog2(AVG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr,
   input  logic [DW-1:0]              din,
   output logic [BURST-1:0][DW-1:0]   mem,
   output logic [SUMW-1:0]            lo_sum,
   output logic [SUMW-1:0]            hi_sum,
   output logic [CW-1:0]              cnt,
   output logic                       full
);
   logic [IDXW-1:0] wptr;
   logic            room;

   assign wptr = clr ? '0 : cnt[IDXW-1:0];
   assign room = clr || (cnt < CW'(BURST));
   assign full = (cnt == CW'(BURST));

   for (genvar g = 0; g < BURST; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr && room && (wptr == IDXW'(g)))
            mem[g] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         lo_sum <= '0;
         hi_sum <= '0;
      end else if (wr && clr) begin
         cnt    <= CW'(1);
         lo_sum <= SUMW'(din);
         hi_sum <= '0;
      end else if (wr && room) begin
         cnt <= cnt + CW'(1);
         if (cnt < CW'(AVG))
            lo_sum <= lo_sum + SUMW'(din);
         if (cnt >= CW'(BURST - AVG))
            hi_sum <= hi_sum + SUMW'(din);
      end
   end
endmodule

// File: rtl/ect_interp.sv
module ect_interp #(
   parameter int DW    = 12,
   parameter int ITER  = 8,
   parameter int AVGL  = 3,
   parameter int EW    = 48,
   parameter bit CUBIC = 1'b1
) (
   input  logic [DW-1:0]          p0,
   input  logic [DW-1:0]          p1,
   input  logic [DW-1:0]          p2,
   input  logic [DW-1:0]          p3,
   input  logic [ITER:0]          m,
   input  logic [DW+AVGL:0]       thr,
   output logic signed [EW-1:0]   err
);
   logic signed [EW-1:0] a0, a1, a2, a3, mm, th, acc;

   assign a0 = EW'(p0);
   assign a1 = EW'(p1);
   assign a2 = EW'(p2);
   assign a3 = EW'(p3);
   assign mm = EW'(m);
   assign th = EW'(thr);

   if (CUBIC) begin : g_cubic
      logic signed [EW-1:0] c1, c2, c3, h2, h1;
      assign c1  = a2 - a0;
      assign c2  = (a0 <<< 1) - ((a1 <<< 2) + a1) + (a2 <<< 2) - a3;
      assign c3  = ((a1 <<< 1) + a1) - ((a2 <<< 1) + a2) + a3 - a0;
      assign h2  = (c2 <<< ITER) + mm * c3;
      assign h1  = (c1 <<< (2 * ITER)) + mm * h2;
      assign acc = (a1 <<< (3 * ITER + 1)) + mm * h1;
   end else begin : g_linear
      logic signed [EW-1:0] slope;
      assign slope = a2 - a1;
      assign acc   = (a1 <<< (3 * ITER + 1)) + ((mm * slope) <<< (2 * ITER + 1));
   end

   assign err = (acc <<< (AVGL + 1)) - (th <<< (3 * ITER + 1));
endmodule

// File: rtl/edge_cross_est.sv
module edge_cross_est
   import ect_pkg::*;
#(
   parameter int DW        = 12,
   parameter int BURST     = 32,
   parameter int AVG       = 8,
   parameter int ITER      = 8,
   parameter int FRACW     = 12,
   parameter int MIN_SWING = 16,
   parameter bit CUBIC     = 1'b1,
   localparam int IDXW     = $clog2(BURST),
   localparam int TW       = IDXW + FRACW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_valid,
   input  logic            smp_start,
   input  logic [DW-1:0]   smp_data,
   input  logic [TW-1:0]   delay_ofs,
   output logic            res_valid,
   output logic            res_ok,
   output logic [TW-1:0]   res_time
);
   localparam int AVGL = $clog2(AVG);
   localparam int REFW = FRACW - ITER;
   localparam int SUMW = DW + AVGL;
   localparam int THRW = SUMW + 1;
   localparam int EW   = DW + 3 * ITER + AVGL + 9;
   localparam int RW   = EW + 2;
   localparam int CW   = $clog2(BURST + 1);
   localparam int ITW  = $clog2(ITER + 1);
   localparam int DSW  = $clog2(REFW + 1);

   if ((1 << AVGL) != AVG) begin : g_bad_avg
      $error("AVG must be a power of two");
   end
   if (BURST < 2 * AVG + 2) begin : g_bad_burst
      $error("BURST too short for the two level windows");
   end
   if (FRACW <= ITER || ITER < 1) begin : g_bad_frac
      $error("FRACW must exceed ITER and ITER must be positive");
   end

   ect_state_t st;

   logic [BURST-1:0][DW-1:0] mem;
   logic [SUMW-1:0]          lo_sum, hi_sum;
   logic [CW-1:0]            cap_cnt;
   logic                     cap_full;
   logic                     start_acc, cap_wr;

   logic [IDXW-1:0]          k, k_m1, k_p1, k_p2;
   logic [ITER:0]            lo_m, hi_m, mid;
   logic [ITER+1:0]          msum;
   logic signed [EW-1:0]     e_lo, e_hi, e_mid, e_first, e_second;
   logic [ITW-1:0]           it;
   logic [DSW-1:0]           ds;
   logic [REFW:0]            q;
   logic [RW-1:0]            rem, rem2, d_val, n_val;
   logic                     good;
   logic                     res_ok_q;
   logic [TW-1:0]            res_time_q;

   logic [THRW-1:0]          thr_s;
   logic [SUMW:0]            need;
   logic                     swing_ok, straddle;
   logic [DW-1:0]            s_k, s_k1;
   logic [FRACW:0]           frac;
   logic [TW-1:0]            t_val;

   assign start_acc = smp_valid && smp_start && (st == S_IDLE || st == S_DONE);
   assign cap_wr    = start_acc || (st == S_CAP && smp_valid);

   ect_capture #(.DW(DW), .BURST(BURST), .AVG(AVG)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_acc),
      .wr     (cap_wr),
      .din    (smp_data),
      .mem    (mem),
      .lo_sum (lo_sum),
      .hi_sum (hi_sum),
      .cnt    (cap_cnt),
      .full   (cap_full)
   );

   // level estimate: threshold kept as a sum of 2*AVG samples
   assign thr_s    = THRW'(lo_sum) + THRW'(hi_sum);
   assign need     = (SUMW+1)'(lo_sum) + (SUMW+1)'(AVG * MIN_SWING);
   assign swing_ok = ((SUMW+1)'(hi_sum) >= need);

   // neighbourhood of the bracketing pair, clamped at burst ends
   assign k_p1 = k + IDXW'(1);
   assign k_m1 = (k == '0) ? '0 : k - IDXW'(1);
   assign k_p2 = (k == IDXW'(BURST - 2)) ? IDXW'(BURST - 1) : k + IDXW'(2);
   assign s_k  = mem[k];
   assign s_k1 = mem[k_p1];

   assign straddle = ({s_k,  {(AVGL+1){1'b0}}} <  thr_s) &&
                     ({s_k1, {(AVGL+1){1'b0}}} >= thr_s);

   assign e_first  = (EW'(s_k)  <<< (AVGL + 3 * ITER + 2)) - (EW'(thr_s) <<< (3 * ITER + 1));
   assign e_second = (EW'(s_k1) <<< (AVGL + 3 * ITER + 2)) - (EW'(thr_s) <<< (3 * ITER + 1));

   assign msum = (ITER+2)'(lo_m) + (ITER+2)'(hi_m);
   assign mid  = msum[ITER+1:1];

   ect_interp #(.DW(DW), .ITER(ITER), .AVGL(AVGL), .EW(EW), .CUBIC(CUBIC)) u_interp (
      .p0  (mem[k_m1]),
      .p1  (s_k),
      .p2  (s_k1),
      .p3  (mem[k_p2]),
      .m   (mid),
      .thr (thr_s),
      .err (e_mid)
   );

   // final linear step: restoring division of the two bracket errors
   assign n_val = RW'(-e_lo);
   assign d_val = RW'(e_hi) - RW'(e_lo);
   assign rem2  = {rem[RW-2:0], 1'b0};

   assign frac  = ((FRACW+1)'(lo_m) << REFW) + (FRACW+1)'(q);
   assign t_val = {k, {FRACW{1'b0}}} + TW'(frac) - delay_ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         k          <= '0;
         lo_m       <= '0;
         hi_m       <= '0;
         e_lo       <= '0;
         e_hi       <= '0;
         it         <= '0;
         ds         <= '0;
         q          <= '0;
         rem        <= '0;
         good       <= 1'b0;
         res_ok_q   <= 1'b0;
         res_time_q <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start_acc) st <= S_CAP;
            end
            S_CAP: begin
               if (cap_full) begin
                  st <= S_SCAN;
                  k  <= '0;
               end
            end
            S_SCAN: begin
               if (!swing_ok) begin
                  good <= 1'b0;
                  st   <= S_FIN;
               end else if (straddle) begin
                  lo_m <= '0;
                  hi_m <= (ITER+1)'(1) << ITER;
                  e_lo <= e_first;
                  e_hi <= e_second;
                  it   <= '0;
                  st   <= S_BIS;
               end else if (k == IDXW'(BURST - 2)) begin
                  good <= 1'b0;
                  st   <= S_FIN;
               end else begin
                  k <= k_p1;
               end
            end
            S_BIS: begin
               if (e_mid >= 0) begin
                  hi_m <= mid;
                  e_hi <= e_mid;
               end else begin
                  lo_m <= mid;
                  e_lo <= e_mid;
               end
               it <= it + ITW'(1);
               if (it == ITW'(ITER - 1)) begin
                  ds <= '0;
                  st <= S_DIV;
               end
            end
            S_DIV: begin
               if (ds == '0) begin
                  if (e_hi == '0) begin
                     q    <= (REFW+1)'(1) << REFW;
                     good <= 1'b1;
                     st   <= S_FIN;
                  end else begin
                     rem <= n_val;
                     q   <= '0;
                     ds  <= DSW'(1);
                  end
               end else begin
                  if (rem2 >= d_val) begin
                     rem <= rem2 - d_val;
                     q   <= {q[REFW-1:0], 1'b1};
                  end else begin
                     rem <= rem2;
                     q   <= {q[REFW-1:0], 1'b0};
                  end
                  if (ds == DSW'(REFW)) begin
                     good <= 1'b1;
                     st   <= S_FIN;
                  end
                  ds <= ds + DSW'(1);
               end
            end
            S_FIN: begin
               res_ok_q   <= good;
               res_time_q <= good ? t_val : '0;
               st         <= S_DONE;
            end
            S_DONE: begin
               st <= start_acc ? S_CAP : S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign res_valid = (st == S_DONE);
   assign res_ok    = res_ok_q;
   assign res_time  = res_time_q;
endmodule

// File: rtl/ect_checker.sv
module ect_checker
   import ect_pkg::*;
#(
   parameter int BURST = 32,
   parameter int ITER  = 8,
   parameter int FRACW = 12,
   localparam int TW   = $clog2(BURST) + FRACW,
   localparam int CW   = $clog2(BURST + 1),
   localparam int LIM  = BURST + FRACW + 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            smp_valid,
   input logic            smp_start,
   input logic            res_valid,
   input logic            res_ok,
   input logic [TW-1:0]   res_time,
   input ect_state_t      st,
   input logic [ITER:0]   lo_m,
   input logic [ITER:0]   hi_m,
   input logic [CW-1:0]   cap_cnt
);
   logic busy;
   logic [$clog2(LIM + 2)-1:0] busy_cyc;

   assign busy = (st == S_SCAN) || (st == S_BIS) || (st == S_DIV) || (st == S_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_cyc <= '0;
      else if (busy)
         busy_cyc <= (busy_cyc > ($clog2(LIM + 2))'(LIM)) ? busy_cyc : busy_cyc + 1'b1;
      else
         busy_cyc <= '0;
   end

   assert_reset_quiet_R11: assert property (@(posedge clk) !rst_n |=> !res_valid);

   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_bad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ok) |-> (res_time == '0));

   assert_bracket_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BIS) |-> (lo_m < hi_m));

   assert_cap_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cap_cnt <= CW'(BURST));

   assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && smp_valid && smp_start) |=> $stable(cap_cnt));

   assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cyc <= ($clog2(LIM + 2))'(LIM));
endmodule

bind edge_cross_est ect_checker #(.BURST(BURST), .ITER(ITER), .FRACW(FRACW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .smp_start (smp_start),
   .res_valid (res_valid),
   .res_ok    (res_ok),
   .res_time  (res_time),
   .st        (st),
   .lo_m      (lo_m),
   .hi_m      (hi_m),
   .cap_cnt   (cap_cnt)
);

// File: tb/tb_edge_cross_est.sv
`timescale 1ns/1ps
module tb_edge_cross_est;
   localparam int BURST = 32;
   localparam int AVG   = 8;
   localparam int MINSW = 16;
   localparam int TW    = 17;
   localparam int TMASK = (1 << TW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic          smp_start = 1'b0;
   logic [11:0]   smp_data = '0;
   logic [TW-1:0] delay_ofs = '0;
   logic          res_valid, res_ok;
   logic [TW-1:0] res_time;

   always #2 clk = ~clk;

   edge_cross_est dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_start (smp_start),
      .smp_data  (smp_data),
      .delay_ofs (delay_ofs),
      .res_valid (res_valid),
      .res_ok    (res_ok),
      .res_time  (res_time)
   );

   int    total = 0;
   int    bad = 0;
   int    nres = 0;
   int    nexp = 0;
   bit    finished = 1'b0;
   int    smp [BURST];
   int    eok_q [$];
   int    et_q [$];
   string tag_q [$];

   task automatic check(input bit pass, input string tag, input int act, input int exp);
      total++;
      if (!pass) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic real cr(input real p0, input real p1, input real p2, input real p3, input real t);
      return 0.5 * (2.0 * p1 + (p2 - p0) * t + (2.0 * p0 - 5.0 * p1 + 4.0 * p2 - p3) * t * t
                    + (3.0 * p1 - p0 - 3.0 * p2 + p3) * t * t * t);
   endfunction

   // reference: levels (R2), bracket (R3), cubic crossing (R4, R5), offset (R6), validity (R7)
   task automatic model(input int ofs, input string tag);
      int lo = 0, hi = 0, ts, k = -1, t;
      real thr, a, b, m, p0, p1, p2, p3;
      for (int i = 0; i < AVG; i++) begin
         lo += smp[i];
         hi += smp[BURST - AVG + i];
      end
      ts = lo + hi;
      if (hi >= lo + AVG * MINSW) begin
         for (int i = 0; i < BURST - 1; i++)
            if (k < 0 && smp[i] * 2 * AVG < ts && smp[i + 1] * 2 * AVG >= ts) k = i;
      end
      if (k < 0) begin
         eok_q.push_back(0);
         et_q.push_back(0);
      end else begin
         thr = real'(ts) / real'(2 * AVG);
         p0 = real'(smp[(k == 0) ? 0 : k - 1]);
         p1 = real'(smp[k]);
         p2 = real'(smp[k + 1]);
         p3 = real'(smp[(k + 2 > BURST - 1) ? BURST - 1 : k + 2]);
         a = 0.0;
         b = 1.0;
         for (int n = 0; n < 40; n++) begin
            m = 0.5 * (a + b);
            if (cr(p0, p1, p2, p3, m) >= thr) b = m;
            else a = m;
         end
         t = k * 4096 + $rtoi(b * 4096.0 + 0.5) - ofs;
         eok_q.push_back(1);
         et_q.push_back(t & TMASK);
      end
      tag_q.push_back(tag);
      nexp++;
   endtask

   task automatic make_ramp(input int lv, input int hv, input real c, input real w);
      real x;
      for (int i = 0; i < BURST; i++) begin
         x = (real'(i) - c) / w + 0.5;
         if (x < 0.0) x = 0.0;
         if (x > 1.0) x = 1.0;
         smp[i] = $rtoi(real'(lv) + real'(hv - lv) * x + 0.5);
      end
   endtask

   // mode 2 inserts invalid cycles with junk data inside the burst (R1)
   task automatic send(input int mode);
      for (int i = 0; i < BURST; i++) begin
         smp_valid = 1'b1;
         smp_start = (i == 0);
         smp_data  = 12'(smp[i]);
         @(negedge clk);
         if (mode == 2 && (i % 5) == 2) begin
            smp_valid = 1'b0;
            smp_start = 1'b1;
            smp_data  = 12'hfff;
            @(negedge clk);
         end
      end
      smp_valid = 1'b0;
      smp_start = 1'b0;
   endtask

   // mode 3 drives false start markers during computation (R9)
   task automatic wait_res(input int mode);
      int c = 0;
      while (!res_valid && c < 2000) begin
         if (mode == 3 && c >= 2 && c < 6) begin
            smp_valid = 1'b1;
            smp_start = 1'b1;
            smp_data  = 12'h7ff;
         end else begin
            smp_valid = 1'b0;
            smp_start = 1'b0;
         end
         c++;
         @(negedge clk);
      end
      smp_valid = 1'b0;
      smp_start = 1'b0;
      check(c <= BURST + 12 + 6, "R12 latency", c, BURST + 18);
   endtask

   always @(negedge clk) begin
      int eo, et, diff;
      string tg;
      if (rst_n && res_valid && !finished) begin
         nres++;
         if (eok_q.size() == 0) begin
            check(1'b0, "R8 unexpected result", 1, 0);
         end else begin
            eo = eok_q.pop_front();
            et = et_q.pop_front();
            tg = tag_q.pop_front();
            check(int'(res_ok) == eo, "R7 valid flag", int'(res_ok), eo);
            if (eo == 0) begin
               check(res_time == '0, "R7 zero time", int'(res_time), 0);
            end else begin
               diff = (int'(res_time) - et) & TMASK;
               if (diff >= (1 << (TW - 1))) diff -= (1 << TW);
               check(diff >= -2 && diff <= 2, tg, int'(res_time), et);
            end
         end
      end
   end

   initial begin
      real   ws [3] = '{1.5, 3.0, 5.0};
      int    n = 0, lv, hv, ofs, mode;
      string tg;
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R11 reset strobe", int'(res_valid), 0);
      check(res_ok == 1'b0, "R11 reset flag", int'(res_ok), 0);
      check(res_time == '0, "R11 reset time", int'(res_time), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int wi = 0; wi < 3; wi++) begin
         for (int j = 0; j < 64; j++) begin
            mode = n % 4;
            lv   = 100 + (n % 7) * 30;
            hv   = lv + 1500 + (n % 5) * 400;
            ofs  = (n * 777) % 5000;
            case (mode)
               0: tg = "R10 R6 back-to-back time";
               1: tg = "R5 R3 idle-start time";
               2: tg = "R1 R4 gapped-burst time";
               default: tg = "R9 R2 false-start time";
            endcase
            if (mode != 0) @(negedge clk);
            if (mode == 1) repeat (3) @(negedge clk);
            delay_ofs = TW'(ofs);
            make_ramp(lv, hv, 12.0 + real'(j) / 8.0, ws[wi]);
            model(ofs, tg);
            send(mode);
            wait_res(mode);
            n++;
         end
      end

      // R7: flat burst, swing at the limit, swing one below, falling edge
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         for (int i = 0; i < BURST; i++) begin
            case (v)
               0: smp[i] = 2000;
               1: smp[i] = (i < BURST / 2) ? 1000 : 1000 + MINSW;
               2: smp[i] = (i < BURST / 2) ? 1000 : 1000 + MINSW - 1;
               default: smp[i] = (i < BURST / 2) ? 3000 : 500;
            endcase
         end
         delay_ofs = TW'(123);
         model(123, "R7 swing boundary time");
         send(1);
         wait_res(1);
      end

      repeat (8) @(negedge clk);
      check(nres == nexp, "R8 result count", nres, nexp);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog R8 actual=%0d expected=%0d", nres, nexp);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule